// File: doc/BRIEF.md
# Register-Mapped Pin Controller with Edge Capture

This block is a general-purpose pin controller with up to 32 pins, reached over a simple 32-bit word-addressed bus. Software sets each pin's direction and output value, reads the pin levels back through a two-stage synchroniser, and enables interrupts pin by pin. Pad cells outside the block take a separate input vector, an output vector and an output-enable vector.

The interrupt trigger is fixed when the block is built. It is one of rising edge, falling edge, both edges or level-high. In the three edge modes, detected edges latch into a capture register that software clears by writing ones. The single interrupt line stays high while any captured and enabled bit is set. In level-high mode the capture register is not used: the line follows the synchronised pin levels under the enable mask.

Top module: `gpio_edge_cap`

## Requirements
- R1: After reset, the output latch, direction, mask and capture registers are all zero, so `pin_oe` is zero, `pin_out` is zero and `irq` is low.
- R2: Registers are at byte offsets 0x0 (pin data), 0x4 (direction), 0x8 (interrupt enable) and 0xC (capture), decoded from `bus_addr[3:2]`. Reads are combinational. A read of offset 0x0 returns the synchronised pin inputs. An access with `bus_addr[1:0]` not zero writes nothing and reads zero.
- R3: Register bits at and above `NUM_PINS` read as zero, and written values there are dropped.
- R4: `pin_oe` equals the direction register (1 means output). `pin_out` equals the latch written through offset 0x0.
- R5: A pin input change shows in a read of offset 0x0 after exactly two rising clock edges.
- R6: In rising-edge mode, a 0-to-1 transition of a synchronised pin sets its capture bit one clock later, and a 1-to-0 transition sets nothing.
- R7: In falling-edge mode only 1-to-0 transitions set capture bits. In both-edge mode either transition sets them.
- R8: In edge modes, `irq` is high exactly while (capture AND enable) is non-zero.
- R9: A write to offset 0xC clears exactly the capture bits written as 1. Writing 0 to a bit leaves it unchanged.
- R10: When a new edge and a clearing write hit the same capture bit in the same cycle, the bit ends up set.
- R11: In level-high mode, `irq` is high exactly while (synchronised pins AND enable) is non-zero, and the capture register stays zero.
- R12: An enable bit of 0 keeps its pin from raising `irq`, whatever the pin or capture state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_wr | input | 1 | Write strobe for the current address |
| bus_addr | input | 4 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| pin_in | input | NUM_PINS | Pad input levels, asynchronous |
| pin_out | output | NUM_PINS | Output latch driven to the pads |
| pin_oe | output | NUM_PINS | Output enable per pad, 1 = drive |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds four copies that share one bus. Three are 12-pin copies in rising, falling and both-edge mode, and the fourth is a 32-pin copy in level-high mode. The 12-pin width leaves twenty unused upper bits, so the zeroing of written values above the pin count can be observed. The 32-pin copy covers the full-width read path with no padding. Because the same pin stimulus reaches all trigger modes at once, each edge can be checked both where it should latch and where it must not. A clearing write is timed to land in the cycle an edge is detected, which exercises the priority rule.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

    typedef enum logic [1:0] {
        TRIG_RISE  = 2'd0,
        TRIG_FALL  = 2'd1,
        TRIG_BOTH  = 2'd2,
        TRIG_LEVEL = 2'd3
    } trig_e;

    localparam int BUS_W    = 32;
    localparam int ADDR_W   = 4;
    localparam int MAX_PINS = 32;

    localparam logic [1:0] IDX_DATA = 2'd0;
    localparam logic [1:0] IDX_DIR  = 2'd1;
    localparam logic [1:0] IDX_MASK = 2'd2;
    localparam logic [1:0] IDX_CAP  = 2'd3;

endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync
    import gpio_pkg::*;
#(
    parameter int    N    = 32,
    parameter trig_e TRIG = TRIG_RISE
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] pin_i,
    output logic [N-1:0] lvl_o,
    output logic [N-1:0] edge_o
);

    typedef struct packed {
        logic [N-1:0] s1;
        logic [N-1:0] s2;
        logic [N-1:0] prev;
    } sync_t;

    sync_t st_d, st_q;
    logic [N-1:0] rise_w, fall_w;

    always_comb begin
        st_d      = st_q;
        st_d.s1   = pin_i;
        st_d.s2   = st_q.s1;
        st_d.prev = st_q.s2;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rise_w = st_q.s2 & ~st_q.prev;
    assign fall_w = ~st_q.s2 & st_q.prev;
    assign lvl_o  = st_q.s2;

    always_comb begin
        case (TRIG)
            TRIG_RISE: edge_o = rise_w;
            TRIG_FALL: edge_o = fall_w;
            TRIG_BOTH: edge_o = rise_w | fall_w;
            default:   edge_o = '0;
        endcase
    end

endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
    import gpio_pkg::*;
#(
    parameter int    N    = 32,
    parameter trig_e TRIG = TRIG_RISE
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [BUS_W-1:0]  wdata_i,
    input  logic [N-1:0]      lvl_i,
    input  logic [N-1:0]      edge_i,
    output logic [BUS_W-1:0]  rdata_o,
    output logic [N-1:0]      out_o,
    output logic [N-1:0]      dir_o,
    output logic [N-1:0]      mask_o,
    output logic [N-1:0]      cap_o
);

    typedef struct packed {
        logic [N-1:0] out;
        logic [N-1:0] dir;
        logic [N-1:0] mask;
        logic [N-1:0] cap;
    } regs_t;

    regs_t        st_d, st_q;
    logic         aligned_w;
    logic [N-1:0] clr_w;

    assign aligned_w = (addr_i[1:0] == 2'b00);

    always_comb begin
        st_d  = st_q;
        clr_w = '0;
        if (wr_i && aligned_w) begin
            case (addr_i[3:2])
                IDX_DATA: st_d.out  = wdata_i[N-1:0];
                IDX_DIR:  st_d.dir  = wdata_i[N-1:0];
                IDX_MASK: st_d.mask = wdata_i[N-1:0];
                default:  clr_w     = wdata_i[N-1:0];
            endcase
        end
        st_d.cap = (st_q.cap & ~clr_w) | edge_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        rdata_o = '0;
        if (aligned_w) begin
            case (addr_i[3:2])
                IDX_DATA: rdata_o = BUS_W'(lvl_i);
                IDX_DIR:  rdata_o = BUS_W'(st_q.dir);
                IDX_MASK: rdata_o = BUS_W'(st_q.mask);
                default:  rdata_o = BUS_W'(st_q.cap);
            endcase
        end
    end

    assign out_o  = st_q.out;
    assign dir_o  = st_q.dir;
    assign mask_o = st_q.mask;
    assign cap_o  = st_q.cap;

    // R9: bits written as one are gone next cycle unless an edge re-set them
    p_w1c_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && addr_i == 4'hC) |=>
            ((st_q.cap & $past(wdata_i[N-1:0] & ~edge_i)) == '0));

    // R10: a detected edge always lands in the capture register
    p_edge_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (|edge_i) |=> ((st_q.cap & $past(edge_i)) == $past(edge_i)));

    generate
        if (TRIG == TRIG_LEVEL) begin : g_lvl_chk
            // R11: capture stays empty in level mode
            p_level_nocap_r11: assert property (@(posedge clk) disable iff (!rst_n)
                st_q.cap == '0);
        end
    endgenerate

endmodule

// File: rtl/gpio_irq.sv
module gpio_irq
    import gpio_pkg::*;
#(
    parameter int    N    = 32,
    parameter trig_e TRIG = TRIG_RISE
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] cap_i,
    input  logic [N-1:0] lvl_i,
    input  logic [N-1:0] mask_i,
    output logic         irq_o
);

    logic [N-1:0] src_w;

    generate
        if (TRIG == TRIG_LEVEL) begin : g_level
            assign src_w = lvl_i;
        end else begin : g_edge
            assign src_w = cap_i;
        end
    endgenerate

    assign irq_o = |(src_w & mask_i);

    // R12: no enabled pin means no request
    p_mask_off_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_i == '0) |-> !irq_o);

endmodule

// File: rtl/gpio_edge_cap.sv
module gpio_edge_cap
    import gpio_pkg::*;
#(
    parameter int    NUM_PINS = 32,
    parameter trig_e TRIG     = TRIG_RISE
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_wr,
    input  logic [3:0]          bus_addr,
    input  logic [31:0]         bus_wdata,
    output logic [31:0]         bus_rdata,
    input  logic [NUM_PINS-1:0] pin_in,
    output logic [NUM_PINS-1:0] pin_out,
    output logic [NUM_PINS-1:0] pin_oe,
    output logic                irq
);

    localparam int N = (NUM_PINS > MAX_PINS) ? MAX_PINS : NUM_PINS;

    logic [N-1:0] lvl_w, edge_w, mask_w, cap_w;

    gpio_in_sync #(.N(N), .TRIG(TRIG)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_i  (pin_in),
        .lvl_o  (lvl_w),
        .edge_o (edge_w)
    );

    gpio_regs #(.N(N), .TRIG(TRIG)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (bus_wr),
        .addr_i  (bus_addr),
        .wdata_i (bus_wdata),
        .lvl_i   (lvl_w),
        .edge_i  (edge_w),
        .rdata_o (bus_rdata),
        .out_o   (pin_out),
        .dir_o   (pin_oe),
        .mask_o  (mask_w),
        .cap_o   (cap_w)
    );

    gpio_irq #(.N(N), .TRIG(TRIG)) u_irq (
        .clk    (clk),
        .rst_n  (rst_n),
        .cap_i  (cap_w),
        .lvl_i  (lvl_w),
        .mask_i (mask_w),
        .irq_o  (irq)
    );

    // R4: a direction write shows on the output enables next cycle
    p_oe_dir_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 4'h4) |=> (pin_oe == $past(bus_wdata[N-1:0])));

    // R1: leaving reset, nothing is driven and no request is raised
    p_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (pin_oe == '0 && pin_out == '0 && !irq));

endmodule

// File: tb/tb_gpio_edge_cap.sv
module tb_gpio_edge_cap;
    import gpio_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] pin_in = '0;

    logic [31:0] rd_r, rd_f, rd_b, rd_l;
    logic [11:0] out_r, oe_r, out_f, oe_f, out_b, oe_b;
    logic [31:0] out_l, oe_l;
    logic        irq_r, irq_f, irq_b, irq_l;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    gpio_edge_cap #(.NUM_PINS(12), .TRIG(TRIG_RISE)) dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(rd_r), .pin_in(pin_in[11:0]),
        .pin_out(out_r), .pin_oe(oe_r), .irq(irq_r));

    gpio_edge_cap #(.NUM_PINS(12), .TRIG(TRIG_FALL)) dut_fall (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(rd_f), .pin_in(pin_in[11:0]),
        .pin_out(out_f), .pin_oe(oe_f), .irq(irq_f));

    gpio_edge_cap #(.NUM_PINS(12), .TRIG(TRIG_BOTH)) dut_both (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(rd_b), .pin_in(pin_in[11:0]),
        .pin_out(out_b), .pin_oe(oe_b), .irq(irq_b));

    gpio_edge_cap #(.NUM_PINS(32), .TRIG(TRIG_LEVEL)) dut_lvl (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(rd_l), .pin_in(pin_in),
        .pin_out(out_l), .pin_oe(oe_l), .irq(irq_l));

    typedef struct packed {
        logic [3:0]  addr;
        logic [31:0] wdata;
        logic [31:0] exp_rd;
        logic [11:0] exp_out;
        logic [11:0] exp_oe;
    } vec_t;

    localparam int NVEC = 8;
    localparam vec_t VECS [NVEC] = '{
        '{4'h4, 32'hFFFF_FFFF, 32'h0000_0FFF, 12'h000, 12'hFFF},
        '{4'h0, 32'h0000_0A5C, 32'h0000_0000, 12'hA5C, 12'hFFF},
        '{4'h8, 32'h0000_F0F0, 32'h0000_00F0, 12'hA5C, 12'hFFF},
        '{4'h4, 32'h0000_0303, 32'h0000_0303, 12'hA5C, 12'h303},
        '{4'h5, 32'h0000_0FFF, 32'h0000_0000, 12'hA5C, 12'h303},
        '{4'h0, 32'hFFFF_F000, 32'h0000_0000, 12'h000, 12'h303},
        '{4'h8, 32'h0000_0000, 32'h0000_0000, 12'h000, 12'h303},
        '{4'h4, 32'h0000_0000, 32'h0000_0000, 12'h000, 12'h000}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [3:0] a);
        bus_wr = 1'b0; bus_addr = a;
        #1;
    endtask

    task automatic wait_neg(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        wait_neg(3);
        rst_n = 1'b1;
        wait_neg(1);

        // R1: reset state
        chk("R1 oe", 32'(oe_r), 32'h0);
        chk("R1 out", 32'(out_r), 32'h0);
        chk("R1 irq", {29'd0, irq_r, irq_f, irq_l}, 32'h0);
        bus_read(4'h4); chk("R1 dir", rd_r, 32'h0);
        bus_read(4'h8); chk("R1 mask", rd_r, 32'h0);
        bus_read(4'hC); chk("R1 cap", rd_b, 32'h0);

        // R2 R3 R4: register table
        for (int i = 0; i < NVEC; i++) begin
            bus_write(VECS[i].addr, VECS[i].wdata);
            bus_read(VECS[i].addr);
            chk("R2 R3 readback", rd_r, VECS[i].exp_rd);
            chk("R4 pin_out", 32'(out_r), 32'(VECS[i].exp_out));
            chk("R4 pin_oe", 32'(oe_r), 32'(VECS[i].exp_oe));
        end

        // R5: two-edge synchroniser latency
        bus_read(4'h0);
        pin_in[0] = 1'b1;
        wait_neg(1); bus_read(4'h0); chk("R5 after one edge", rd_l, 32'h0);
        wait_neg(1); bus_read(4'h0); chk("R5 after two edges", rd_l, 32'h1);
        wait_neg(2);

        // R6 R7 R11: rising edge seen by rise and both only
        bus_read(4'hC);
        chk("R6 rise cap", rd_r, 32'h1);
        chk("R7 fall cap on rise", rd_f, 32'h0);
        chk("R7 both cap", rd_b, 32'h1);
        chk("R11 level cap", rd_l, 32'h0);
        // R12: masked, no request even with capture and a high pin
        chk("R12 irq masked", {28'd0, irq_r, irq_f, irq_b, irq_l}, 32'h0);

        // R8 R11: enable pin 0
        bus_write(4'h8, 32'h1);
        chk("R8 irq rise", {31'd0, irq_r}, 32'h1);
        chk("R8 irq fall", {31'd0, irq_f}, 32'h0);
        chk("R8 irq both", {31'd0, irq_b}, 32'h1);
        chk("R11 irq level high", {31'd0, irq_l}, 32'h1);

        // R7 R11: falling edge
        pin_in[0] = 1'b0;
        wait_neg(4);
        bus_read(4'hC);
        chk("R7 fall cap", rd_f, 32'h1);
        chk("R6 rise cap kept", rd_r, 32'h1);
        chk("R11 irq level low", {31'd0, irq_l}, 32'h0);
        chk("R8 irq fall", {31'd0, irq_f}, 32'h1);

        // R9: writing zero keeps, writing one clears
        bus_write(4'hC, 32'h0);
        bus_read(4'hC); chk("R9 zero write keeps", rd_r, 32'h1);
        bus_write(4'hC, 32'h1);
        bus_read(4'hC);
        chk("R9 clear rise", rd_r, 32'h0);
        chk("R9 clear fall", rd_f, 32'h0);
        chk("R8 irq after clear", {29'd0, irq_r, irq_f, irq_b}, 32'h0);

        // R10: clear lands in the cycle the edge is detected
        @(negedge clk);
        pin_in[1] = 1'b1;
        wait_neg(1);
        bus_write(4'hC, 32'h2);
        bus_read(4'hC);
        chk("R10 edge wins", rd_r, 32'h2);
        chk("R10 edge wins both", rd_b, 32'h2);
        chk("R12 bit1 masked", {31'd0, irq_r}, 32'h0);
        bus_write(4'h8, 32'h2);
        chk("R8 bit1 enabled", {31'd0, irq_r}, 32'h1);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule